// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indicator

This block is the comparison stage of a digital frequency synthesizer loop. It takes two pulse trains that are sampled on the system clock: a divided reference train and a divided oscillator train. It reports which of the two produced a rising edge first, and for how many clock cycles it led.

The core holds two state flops. One is an advance request, set by a reference edge. The other is a retard request, set by an oscillator edge. Once both are set, a counter holds them together for a programmable number of cycles and then clears both. This short common pulse keeps the detector free of a dead zone near zero phase error.

The two flops drive three outputs:
- a three-state style error output, given as separate drive-high, drive-low and enable lines;
- an active-low pair that pulses once per comparison;
- a lock flag that drops only while a one-sided error has lasted longer than the common pulse.

Top module: `pfd_lockdet`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it is asserted, the outputs are idle: `err_drv_en`=0, `err_drv_hi`=0, `err_drv_lo`=0, `ref_err_n`=1, `osc_err_n`=1 and `lock_o`=1.
- R2: A rising edge on an input sets the error state at the second clock edge after the input was first sampled high. For a one-sided error, `err_drv_en` is first seen high two cycles after the earlier input edge is driven.
- R3: When the oscillator edge lags the reference edge by d cycles (oscillator slower or lagging), `err_drv_hi`=1 and `err_drv_en`=1 for exactly d cycles per comparison, and `err_drv_lo` stays 0.
- R4: When the oscillator edge leads the reference edge by d cycles (oscillator faster or leading), `err_drv_lo`=1 and `err_drv_en`=1 for exactly d cycles per comparison, and `err_drv_hi` stays 0.
- R5: When both edges fall in the same cycle, `err_drv_en` stays 0, so the single-ended output is never driven.
- R6: On the pair, a lagging oscillator holds `ref_err_n` low for d+MIN_W cycles, while `osc_err_n` is low only for the MIN_W common cycles.
- R7: On the pair, a leading oscillator holds `osc_err_n` low for d+MIN_W cycles, while `ref_err_n` is low only for the MIN_W common cycles.
- R8: On every comparison, both pair outputs are low together for exactly MIN_W consecutive cycles, never longer, and then both return high.
- R9: `lock_o` is 0 only on a cycle where exactly one error flop is set and MIN_W or more cycles of that one-sided error have already passed. A comparison with skew d therefore drops lock for max(0, d-MIN_W) cycles.
- R10: A second rising edge on the same input, arriving while that input's error flop is still set and the other input has not yet answered, is absorbed. The error width is then counted from the first edge.
- R11: With the oscillator running at a steadily higher rate than the reference, `err_drv_hi` never asserts and `err_drv_lo` does. At a steadily lower rate, `err_drv_lo` never asserts and `err_drv_hi` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_in | input | 1 | Divided reference pulse train |
| osc_in | input | 1 | Divided oscillator pulse train |
| err_drv_hi | output | 1 | Single-ended error: drive high (oscillator lagging) |
| err_drv_lo | output | 1 | Single-ended error: drive low (oscillator leading) |
| err_drv_en | output | 1 | Single-ended error: output enable (0 = high impedance) |
| ref_err_n | output | 1 | Active-low pulse, long when the oscillator lags |
| osc_err_n | output | 1 | Active-low pulse, long when the oscillator leads |
| lock_o | output | 1 | Lock indicator, low only during an extended one-sided error |

## Verification
The assertions take for granted that each input stays low for at least one sampled cycle between rising edges. They also assume that MIN_W is at least 1, so every comparison ends in a common pulse that the counters can see. The stimulus keeps every high and low phase at three or more cycles. It spaces single comparisons far enough apart that each one clears before the next edge. In the rate-mismatch runs, the periods ensure that every edge of the slower train has at least one edge of the faster train before it.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Encoding of the two error flops, bit 0 = advance, bit 1 = retard
  typedef enum logic [1:0] {
    PFD_IDLE = 2'b00,
    PFD_ADV  = 2'b01,
    PFD_RET  = 2'b10,
    PFD_BOTH = 2'b11
  } pfd_state_e;

  // Bits needed to hold the value v
  function automatic int unsigned pfd_cnt_w(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/pfd_rst_sync.sv
module pfd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
  parameter int unsigned CH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] sig_in,
  output logic [CH-1:0] rise_o
);

  for (genvar g = 0; g < CH; g++) begin : g_ch
    logic smp_q, prev_q;
    logic smp_d, prev_d;

    always_comb begin
      smp_d  = sig_in[g];
      prev_d = smp_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        smp_q  <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        smp_q  <= smp_d;
        prev_q <= prev_d;
      end
    end

    assign rise_o[g] = smp_q & ~prev_q;
  end

endmodule

// File: rtl/pfd_state_core.sv
module pfd_state_core
  import pfd_pkg::*;
#(
  parameter int unsigned MIN_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise_ref,
  input  logic       rise_osc,
  output pfd_state_e state_o
);

  localparam int unsigned CW = pfd_cnt_w(MIN_W);

  logic          adv_q, ret_q;
  logic          adv_d, ret_d;
  logic [CW-1:0] hold_q, hold_d;
  logic          hold_en;
  logic          both, clr;

  always_comb begin
    both    = adv_q & ret_q;
    clr     = both && (hold_q == CW'(MIN_W - 1));
    hold_en = both | (hold_q != '0);
    if (clr) begin
      // a fresh edge in the clearing cycle starts the next comparison
      adv_d  = rise_ref;
      ret_d  = rise_osc;
      hold_d = '0;
    end else begin
      adv_d  = adv_q | rise_ref;
      ret_d  = ret_q | rise_osc;
      hold_d = both ? hold_q + CW'(1) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adv_q <= 1'b0;
      ret_q <= 1'b0;
    end else begin
      adv_q <= adv_d;
      ret_q <= ret_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  assign state_o = pfd_state_e'({ret_q, adv_q});

endmodule

// File: rtl/pfd_out_lock.sv
module pfd_out_lock
  import pfd_pkg::*;
#(
  parameter int unsigned MIN_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  pfd_state_e state_i,
  output logic       drv_hi,
  output logic       drv_lo,
  output logic       drv_en,
  output logic       ref_n,
  output logic       osc_n,
  output logic       lock
);

  localparam int unsigned CW = pfd_cnt_w(MIN_W);

  logic [CW-1:0] skew_q, skew_d;
  logic          skew_en;
  logic          one_sided;

  always_comb begin
    one_sided = (state_i == PFD_ADV) || (state_i == PFD_RET);
    skew_en   = one_sided | (skew_q != '0);
    if (!one_sided) begin
      skew_d = '0;
    end else if (skew_q == CW'(MIN_W)) begin
      skew_d = skew_q;
    end else begin
      skew_d = skew_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skew_q <= '0;
    end else if (skew_en) begin
      skew_q <= skew_d;
    end
  end

  always_comb begin
    drv_hi = (state_i == PFD_ADV);
    drv_lo = (state_i == PFD_RET);
    drv_en = one_sided;
    ref_n  = !((state_i == PFD_ADV) || (state_i == PFD_BOTH));
    osc_n  = !((state_i == PFD_RET) || (state_i == PFD_BOTH));
    lock   = !(one_sided && (skew_q >= CW'(MIN_W)));
  end

endmodule

// File: rtl/pfd_lockdet.sv
module pfd_lockdet
  import pfd_pkg::*;
#(
  parameter int unsigned MIN_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic osc_in,
  output logic err_drv_hi,
  output logic err_drv_lo,
  output logic err_drv_en,
  output logic ref_err_n,
  output logic osc_err_n,
  output logic lock_o
);

  logic       rst_core_n;
  logic [1:0] rise;
  pfd_state_e state;

  pfd_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  pfd_edge_det #(.CH(2)) edge_i (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .sig_in ({osc_in, ref_in}),
    .rise_o (rise)
  );

  pfd_state_core #(.MIN_W(MIN_W)) core_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rise_ref (rise[0]),
    .rise_osc (rise[1]),
    .state_o  (state)
  );

  pfd_out_lock #(.MIN_W(MIN_W)) out_i (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .state_i (state),
    .drv_hi  (err_drv_hi),
    .drv_lo  (err_drv_lo),
    .drv_en  (err_drv_en),
    .ref_n   (ref_err_n),
    .osc_n   (osc_err_n),
    .lock    (lock_o)
  );

endmodule

// File: rtl/pfd_lockdet_chk.sv
module pfd_lockdet_chk
  import pfd_pkg::*;
#(
  parameter int unsigned MIN_W = 2
) (
  input logic clk,
  input logic rst_n,
  input logic err_drv_hi,
  input logic err_drv_lo,
  input logic err_drv_en,
  input logic ref_err_n,
  input logic osc_err_n,
  input logic lock_o
);

  localparam int unsigned RW = pfd_cnt_w(MIN_W + 1);

  logic [RW-1:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q <= '0;
    end else if (!ref_err_n && !osc_err_n) begin
      if (low_run_q != RW'(MIN_W + 1)) low_run_q <= low_run_q + RW'(1);
    end else begin
      low_run_q <= '0;
    end
  end

  // R1
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!err_drv_en && ref_err_n && osc_err_n && lock_o));

  // R3
  no_dual_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_drv_hi && err_drv_lo));

  // R5
  drive_needs_split_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_drv_en |-> (ref_err_n != osc_err_n));

  // R8
  common_pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_run_q <= RW'(MIN_W));

  // R9
  lock_drop_needs_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_o |-> (err_drv_en && $past(err_drv_en)));

endmodule

bind pfd_lockdet pfd_lockdet_chk #(.MIN_W(MIN_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .err_drv_hi (err_drv_hi),
  .err_drv_lo (err_drv_lo),
  .err_drv_en (err_drv_en),
  .ref_err_n  (ref_err_n),
  .osc_err_n  (osc_err_n),
  .lock_o     (lock_o)
);

// File: tb/pfd_lockdet_tb_top.sv
module pfd_lockdet_tb_top;

  localparam int MW = 3;

  logic clk, rst_n, ref_in, osc_in;
  logic err_drv_hi, err_drv_lo, err_drv_en, ref_err_n, osc_err_n, lock_o;

  int total, bad;
  int hi_c, lo_c, en_c, rl_c, ol_c, both_c, ll_c, first_en;
  bit done;

  pfd_lockdet #(.MIN_W(MW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .osc_in(osc_in),
    .err_drv_hi(err_drv_hi), .err_drv_lo(err_drv_lo), .err_drv_en(err_drv_en),
    .ref_err_n(ref_err_n), .osc_err_n(osc_err_n), .lock_o(lock_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clr_counts();
    hi_c = 0; lo_c = 0; en_c = 0; rl_c = 0; ol_c = 0; both_c = 0; ll_c = 0;
    first_en = -1;
  endtask

  task automatic sample(input int c);
    if (err_drv_hi) hi_c++;
    if (err_drv_lo) lo_c++;
    if (err_drv_en) begin
      en_c++;
      if (first_en < 0) first_en = c;
    end
    if (!ref_err_n) rl_c++;
    if (!osc_err_n) ol_c++;
    if (!ref_err_n && !osc_err_n) both_c++;
    if (!lock_o) ll_c++;
  endtask

  task automatic idle_check(input string req);
    chk(req, "err_drv_en", int'(err_drv_en), 0);
    chk(req, "err_drv_hi|lo", int'(err_drv_hi | err_drv_lo), 0);
    chk(req, "ref_err_n", int'(ref_err_n), 1);
    chk(req, "osc_err_n", int'(osc_err_n), 1);
    chk(req, "lock_o", int'(lock_o), 1);
  endtask

  // one comparison: reference rises at cycle 8, oscillator at 8+d
  task automatic run_offset(input int d);
    int a;
    a = (d < 0) ? -d : d;
    clr_counts();
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      sample(c);
      ref_in = (c >= 8) && (c < 12);
      osc_in = (c >= 8 + d) && (c < 12 + d);
    end
    chk("R3", $sformatf("hi cycles d=%0d", d), hi_c, (d > 0) ? a : 0);
    chk("R4", $sformatf("lo cycles d=%0d", d), lo_c, (d < 0) ? a : 0);
    chk("R5", $sformatf("en cycles d=%0d", d), en_c, a);
    chk("R6", $sformatf("ref_err_n low d=%0d", d), rl_c, ((d > 0) ? a : 0) + MW);
    chk("R7", $sformatf("osc_err_n low d=%0d", d), ol_c, ((d < 0) ? a : 0) + MW);
    chk("R8", $sformatf("common low d=%0d", d), both_c, MW);
    chk("R9", $sformatf("lock low d=%0d", d), ll_c, (a > MW) ? a - MW : 0);
    if (d != 0)
      chk("R2", $sformatf("first enable d=%0d", d), first_en, 10 + ((d < 0) ? d : 0));
  endtask

  // two trains with given periods; high phase 3 cycles
  task automatic run_rates(input int rp, input int r0, input int op, input int o0);
    clr_counts();
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      sample(c);
      ref_in = (c >= r0) && (((c - r0) % rp) < 3);
      osc_in = (c >= o0) && (((c - o0) % op) < 3);
    end
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      ref_in = 1'b0;
      osc_in = 1'b0;
    end
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; ref_in = 1'b0; osc_in = 1'b0;
    repeat (3) @(negedge clk);
    idle_check("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_check("R1");

    for (int d = -7; d <= 7; d++) run_offset(d);

    // R10: two reference edges before one oscillator edge
    clr_counts();
    for (int c = 0; c < 45; c++) begin
      @(negedge clk);
      sample(c);
      ref_in = ((c >= 8) && (c < 11)) || ((c >= 16) && (c < 19));
      osc_in = (c >= 24) && (c < 27);
    end
    chk("R10", "absorbed edge hi cycles", hi_c, 16);
    chk("R10", "absorbed edge lo cycles", lo_c, 0);

    // R11: oscillator faster, then slower
    run_rates(10, 3, 7, 0);
    chk("R11", "fast osc hi cycles", hi_c, 0);
    chk("R11", "fast osc lo seen", int'(lo_c > 0), 1);
    chk("R9", "fast osc lock drop seen", int'(ll_c > 0), 1);
    run_rates(10, 0, 13, 3);
    chk("R11", "slow osc lo cycles", lo_c, 0);
    chk("R11", "slow osc hi seen", int'(hi_c > 0), 1);

    // R1: reset in the middle of a one-sided error
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      ref_in = (c >= 1) && (c < 4);
    end
    chk("R1", "pre-reset error active", int'(err_drv_hi), 1);
    rst_n = 1'b0;
    @(negedge clk);
    idle_check("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_check("R1");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule